// File: doc/BRIEF.md
# Scratchpad Bank Transfer Unit

This unit moves bytes between a processor's register file and a set of shadow register banks. Each bank mirrors the register file: 32 words of 32 bits, held as four byte lanes per word. A request names an operation, a device ID, a starting register, a starting byte lane and a byte count. Read-in copies bank bytes into registers. Write-out copies register bytes into the bank. Exchange swaps the two. Register N, lane B always pairs with bank word N, lane B, so no byte ever moves to a different lane.

The unit handles one byte per clock. After lane 3 it returns to lane 0 of the next register. Two reserved device IDs on read-in act as pseudo-banks: one writes all-ones and the other writes all-zeros into the addressed register bytes. The request is checked when it arrives. A request with an unknown device, a pseudo-bank used for anything but read-in, an unused operation code, or a byte range that runs past the end of the register file is refused with a one-cycle error pulse, and no byte moves. The register file stays outside the unit and is reached through a one-byte read/write port that the unit addresses.

Top module: `spx_xfer_top`

## Requirements
- R1: Read-in (op code 0) writes the byte at bank word N, lane B into register N, lane B, for every byte in the range. Lanes are never shifted, and the bank is not changed.
- R2: Write-out (op code 1) writes register N, lane B into bank word N, lane B, for every byte in the range. The register file is not written.
- R3: Exchange (op code 2) swaps each addressed register byte with the matching bank byte. Both reads of a byte happen before either write of that byte.
- R4: Bytes are handled one per cycle in ascending order, starting at the given register and lane. After lane 3 the next byte is lane 0 of the next register.
- R5: Device IDs 10, 11 and 12 select three local banks and ID 14 selects a peer bank. The four banks hold separate contents.
- R6: On read-in, device ID 254 writes 0xFF and ID 255 writes 0x00 into every addressed register byte. No bank changes.
- R7: A request is refused when the device ID is not one of 10, 11, 12, 14, or 254/255 with op code 0, or when the op code is 3. A refused request raises `err` for one cycle, one cycle after it is presented, and writes nothing to the registers or the banks.
- R8: A request is refused as in R7 when start register × 4 + start lane + length exceeds 128. A sum of exactly 128 is accepted.
- R9: An accepted request of L bytes raises `done` for one cycle, L+1 cycles after the request cycle. A length of 0 raises `done` one cycle after the request and moves nothing. `done` and `err` are never high together.
- R10: While `busy` is high, any new request is ignored. It causes no transfer, no `done` and no `err`.
- R11: After reset, `busy`, `done` and `err` are low and every bank byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle (taken only when not busy) |
| req_op | input | 2 | 0 read-in, 1 write-out, 2 exchange, 3 refused |
| req_dev | input | 8 | Device ID |
| req_reg | input | 5 | Starting register number |
| req_lane | input | 2 | Starting byte lane |
| req_len | input | 8 | Byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| rf_reg | output | 5 | Register number of the current byte |
| rf_lane | output | 2 | Byte lane of the current byte |
| rf_rdata | input | 8 | Register byte at rf_reg/rf_lane (combinational) |
| rf_we | output | 1 | Register byte write enable |
| rf_wdata | output | 8 | Register byte write data |

## Verification
The assertions check the following on every cycle: the lane cursor wraps into the next register, `done` and `err` never coincide, a refusal never starts a transfer, `done` only follows activity, and nothing is written while the unit is idle. The remaining behaviour can only be shown by the bench's scenarios, which compare the register file and the bank contents against a model. These cover lane alignment, exchange atomicity per byte, the fill values, the independence of the banks, the exact-fit bound, and that a request made while busy leaves the target bank untouched.

// File: rtl/spx_pkg.sv
package spx_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_XCHG  = 2'd2,
        OP_RSVD  = 2'd3
    } spx_op_e;
endpackage

// File: rtl/spx_req_check.sv
module spx_req_check
    import spx_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int LANES      = 4,
    parameter int LEN_W      = 8,
    parameter int ID_W       = 8,
    parameter int NUM_LOCAL  = 3,
    parameter int LOCAL_BASE = 10,
    parameter int PEER_ID    = 14,
    parameter int ONES_ID    = 254,
    parameter int ZEROS_ID   = 255,
    localparam int REG_W     = $clog2(NUM_REGS),
    localparam int LANE_W    = $clog2(LANES),
    localparam int NUM_BANKS = NUM_LOCAL + 1,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  spx_op_e             op,
    input  logic [ID_W-1:0]     dev,
    input  logic [REG_W-1:0]    start_reg,
    input  logic [LANE_W-1:0]   start_lane,
    input  logic [LEN_W-1:0]    len,
    output logic                ok,
    output logic [BANK_W-1:0]   bank,
    output logic                fill,
    output logic [7:0]          fill_byte
);
    localparam int SPAN_W = REG_W + LANE_W + LEN_W + 1;
    localparam int LIMIT  = NUM_REGS * LANES;

    logic              dev_ok;
    logic [SPAN_W-1:0] span;

    always_comb begin
        dev_ok    = 1'b0;
        bank      = '0;
        fill      = 1'b0;
        fill_byte = 8'h00;
        for (int i = 0; i < NUM_LOCAL; i++) begin
            if (dev == ID_W'(LOCAL_BASE + i)) begin
                dev_ok = 1'b1;
                bank   = BANK_W'(i);
            end
        end
        if (dev == ID_W'(PEER_ID)) begin
            dev_ok = 1'b1;
            bank   = BANK_W'(NUM_LOCAL);
        end
        if (op == OP_READ && (dev == ID_W'(ONES_ID) || dev == ID_W'(ZEROS_ID))) begin
            dev_ok    = 1'b1;
            fill      = 1'b1;
            fill_byte = (dev == ID_W'(ONES_ID)) ? 8'hFF : 8'h00;
        end
        span = SPAN_W'(start_reg) * SPAN_W'(LANES) + SPAN_W'(start_lane) + SPAN_W'(len);
        ok   = dev_ok && (op != OP_RSVD) && (span <= SPAN_W'(LIMIT));
    end
endmodule

// File: rtl/spx_seq.sv
module spx_seq
    import spx_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int LANES     = 4,
    parameter int LEN_W     = 8,
    parameter int BANK_W    = 2,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int LANE_W   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  spx_op_e            req_op,
    input  logic [REG_W-1:0]   req_reg,
    input  logic [LANE_W-1:0]  req_lane,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               chk_ok,
    input  logic [BANK_W-1:0]  chk_bank,
    input  logic               chk_fill,
    input  logic [7:0]         chk_fill_byte,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [REG_W-1:0]   cur_reg,
    output logic [LANE_W-1:0]  cur_lane,
    output spx_op_e            cur_op,
    output logic [BANK_W-1:0]  cur_bank,
    output logic               cur_fill,
    output logic [7:0]         cur_fill_byte
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic              err;
        logic [REG_W-1:0]  rg;
        logic [LANE_W-1:0] lane;
        logic [LEN_W-1:0]  left;
        spx_op_e           op;
        logic [BANK_W-1:0] bank;
        logic              fill;
        logic [7:0]        fill_byte;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                if (!chk_ok) begin
                    st_d.err = 1'b1;
                end else if (req_len == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy      = 1'b1;
                    st_d.rg        = req_reg;
                    st_d.lane      = req_lane;
                    st_d.left      = req_len;
                    st_d.op        = req_op;
                    st_d.bank      = chk_bank;
                    st_d.fill      = chk_fill;
                    st_d.fill_byte = chk_fill_byte;
                end
            end
        end else begin
            if (st_q.left == LEN_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
            st_d.left = st_q.left - LEN_W'(1);
            if (st_q.lane == LANE_W'(LANES - 1)) begin
                st_d.lane = '0;
                st_d.rg   = st_q.rg + REG_W'(1);
            end else begin
                st_d.lane = st_q.lane + LANE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= OP_READ;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy          = st_q.busy;
    assign done          = st_q.done;
    assign err           = st_q.err;
    assign cur_reg       = st_q.rg;
    assign cur_lane      = st_q.lane;
    assign cur_op        = st_q.op;
    assign cur_bank      = st_q.bank;
    assign cur_fill      = st_q.fill;
    assign cur_fill_byte = st_q.fill_byte;

    AST_LANE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy) && $past(st_q.lane) == LANE_W'(LANES - 1))
        |-> (st_q.lane == '0 && st_q.rg == REG_W'($past(st_q.rg) + REG_W'(1)))); // R4

    AST_DONE_ERR_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.done && st_q.err)); // R9

    AST_REFUSE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !st_q.busy); // R7

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> ($past(st_q.busy) || $past(req_valid))); // R9
endmodule

// File: rtl/spx_bank_store.sv
module spx_bank_store #(
    parameter int NUM_BANKS = 4,
    parameter int NUM_REGS  = 32,
    parameter int LANES     = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int LANE_W   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BANK_W-1:0]  bank,
    input  logic [REG_W-1:0]   rg,
    input  logic [LANE_W-1:0]  lane,
    input  logic               we,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata
);
    logic [7:0] rd_all [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [7:0] mem_q [NUM_REGS][LANES];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int r = 0; r < NUM_REGS; r++) begin
                    for (int l = 0; l < LANES; l++) begin
                        mem_q[r][l] <= 8'h00;
                    end
                end
            end else if (we && bank == BANK_W'(b)) begin
                mem_q[rg][lane] <= wdata;
            end
        end

        assign rd_all[b] = mem_q[rg][lane];
    end

    assign rdata = rd_all[bank];
endmodule

// File: rtl/spx_xfer_top.sv
module spx_xfer_top
    import spx_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 8,
    parameter int ID_W       = 8,
    parameter int NUM_LOCAL  = 3,
    parameter int LOCAL_BASE = 10,
    parameter int PEER_ID    = 14,
    parameter int ONES_ID    = 254,
    parameter int ZEROS_ID   = 255,
    localparam int LANES     = DATA_W / 8,
    localparam int REG_W     = $clog2(NUM_REGS),
    localparam int LANE_W    = $clog2(LANES),
    localparam int NUM_BANKS = NUM_LOCAL + 1,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ID_W-1:0]   req_dev,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [LANE_W-1:0] req_lane,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [REG_W-1:0]  rf_reg,
    output logic [LANE_W-1:0] rf_lane,
    input  logic [7:0]        rf_rdata,
    output logic              rf_we,
    output logic [7:0]        rf_wdata
);
    spx_op_e           op_in, cur_op;
    logic              chk_ok, chk_fill, cur_fill;
    logic [BANK_W-1:0] chk_bank, cur_bank;
    logic [7:0]        chk_fill_byte, cur_fill_byte, bank_rdata;
    logic              bank_we;

    assign op_in = spx_op_e'(req_op);

    spx_req_check #(
        .NUM_REGS(NUM_REGS), .LANES(LANES), .LEN_W(LEN_W), .ID_W(ID_W),
        .NUM_LOCAL(NUM_LOCAL), .LOCAL_BASE(LOCAL_BASE), .PEER_ID(PEER_ID),
        .ONES_ID(ONES_ID), .ZEROS_ID(ZEROS_ID)
    ) u_check (
        .op(op_in), .dev(req_dev), .start_reg(req_reg), .start_lane(req_lane),
        .len(req_len), .ok(chk_ok), .bank(chk_bank), .fill(chk_fill),
        .fill_byte(chk_fill_byte)
    );

    spx_seq #(
        .NUM_REGS(NUM_REGS), .LANES(LANES), .LEN_W(LEN_W), .BANK_W(BANK_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_in),
        .req_reg(req_reg), .req_lane(req_lane), .req_len(req_len),
        .chk_ok(chk_ok), .chk_bank(chk_bank), .chk_fill(chk_fill),
        .chk_fill_byte(chk_fill_byte), .busy(busy), .done(done), .err(err),
        .cur_reg(rf_reg), .cur_lane(rf_lane), .cur_op(cur_op),
        .cur_bank(cur_bank), .cur_fill(cur_fill), .cur_fill_byte(cur_fill_byte)
    );

    assign bank_we  = busy && (cur_op == OP_WRITE || cur_op == OP_XCHG);
    assign rf_we    = busy && (cur_op == OP_READ  || cur_op == OP_XCHG);
    assign rf_wdata = cur_fill ? cur_fill_byte : bank_rdata;

    spx_bank_store #(
        .NUM_BANKS(NUM_BANKS), .NUM_REGS(NUM_REGS), .LANES(LANES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .bank(cur_bank), .rg(rf_reg), .lane(rf_lane),
        .we(bank_we), .wdata(rf_rdata), .rdata(bank_rdata)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rf_we && !bank_we)); // R10

    AST_FILL_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_fill) |-> (cur_op == OP_READ)); // R6
endmodule

// File: tb/spx_xfer_top_tb.sv
module spx_xfer_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_dev = 8'd0;
    logic [4:0] req_reg = 5'd0;
    logic [1:0] req_lane = 2'd0;
    logic [7:0] req_len = 8'd0;
    logic       busy, done, err, rf_we;
    logic [4:0] rf_reg;
    logic [1:0] rf_lane;
    logic [7:0] rf_rdata, rf_wdata;

    logic [7:0] rf      [32][4];
    logic [7:0] exp_rf  [32][4];
    logic [7:0] exp_bk  [4][32][4];

    typedef struct {
        bit    is_err;
        int    lat;
        int    issued;
        string tag;
    } exp_t;
    exp_t sbq[$];
    exp_t mon_e;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    spx_xfer_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_dev(req_dev), .req_reg(req_reg), .req_lane(req_lane),
        .req_len(req_len), .busy(busy), .done(done), .err(err),
        .rf_reg(rf_reg), .rf_lane(rf_lane), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_wdata(rf_wdata)
    );

    assign rf_rdata = rf[rf_reg][rf_lane];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rf_we) rf[rf_reg][rf_lane] <= rf_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor: every done/err pulse is matched to the oldest expectation
    always @(negedge clk) begin
        if (rst_n && (done || err)) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10", "unexpected result pulse", {done, err}, 0);
            end else begin
                mon_e = sbq.pop_front();
                chk(err == mon_e.is_err && done == !mon_e.is_err,
                    mon_e.tag, "result kind (err)", err, mon_e.is_err);
                chk(cyc - mon_e.issued == mon_e.lat, mon_e.tag, "latency",
                    cyc - mon_e.issued, mon_e.lat);
                chk(!(done && err), "R9", "done with err", 1, 0);
            end
        end
    end

    function automatic int bank_of(input int dev);
        if (dev >= 10 && dev <= 12) return dev - 10;
        if (dev == 14) return 3;
        return -1;
    endfunction

    task automatic check_rf(input string req);
        int bad = 0, br = 0, bl = 0;
        for (int r = 0; r < 32; r++)
            for (int l = 0; l < 4; l++)
                if (rf[r][l] !== exp_rf[r][l]) begin
                    if (bad == 0) begin br = r; bl = l; end
                    bad++;
                end
        chk(bad == 0, req, $sformatf("register image r%0d.%0d", br, bl),
            rf[br][bl], exp_rf[br][bl]);
    endtask

    task automatic load_rf(input int seed);
        for (int r = 0; r < 32; r++)
            for (int l = 0; l < 4; l++) begin
                rf[r][l]     = 8'(r * 4 * 7 + l * 7 + seed * 13 + 1);
                exp_rf[r][l] = rf[r][l];
            end
    endtask

    task automatic start_req(input int op, input int dev, input int rg, input int ln,
                             input int len, input string tag);
        bit   bad;
        int   b, r, l;
        exp_t e;
        logic [7:0] t;
        b   = bank_of(dev);
        bad = (op == 3) || (rg * 4 + ln + len > 128) ||
              !(b >= 0 || (op == 0 && (dev == 254 || dev == 255)));
        if (!bad) begin
            r = rg; l = ln;
            for (int k = 0; k < len; k++) begin
                if (op == 0) exp_rf[r][l] = (dev == 254) ? 8'hFF :
                                            (dev == 255) ? 8'h00 : exp_bk[b][r][l];
                else if (op == 1) exp_bk[b][r][l] = exp_rf[r][l];
                else begin
                    t = exp_rf[r][l];
                    exp_rf[r][l] = exp_bk[b][r][l];
                    exp_bk[b][r][l] = t;
                end
                if (l == 3) begin l = 0; r++; end else l++;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_dev = 8'(dev);
        req_reg = 5'(rg); req_lane = 2'(ln); req_len = 8'(len);
        e.is_err = bad;
        e.lat    = bad ? 1 : len + 1;
        e.issued = cyc;
        e.tag    = tag;
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (sbq.size() > 0 || busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(input int op, input int dev, input int rg, input int ln,
                        input int len, input string tag);
        start_req(op, dev, rg, ln, len, tag);
        wait_idle();
    endtask

    task automatic dump_bank(input int dev, input string tag);
        xfer(0, dev, 0, 0, 128, tag);
        check_rf(tag);
    endtask

    initial begin
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 32; r++)
                for (int l = 0; l < 4; l++) exp_bk[b][r][l] = 8'h00;
        load_rf(1);
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0, "R11", "outputs in reset",
            {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0, "R11", "outputs after reset",
            {busy, done, err}, 0);
        dump_bank(10, "R11");
        dump_bank(14, "R11");

        // R2 R4: write-out across a lane wrap, then read back whole bank (R1)
        load_rf(2);
        xfer(1, 10, 3, 1, 9, "R2");
        check_rf("R2");
        load_rf(3);
        dump_bank(10, "R1");
        load_rf(4);
        xfer(0, 10, 3, 3, 3, "R4");
        check_rf("R4");

        // R5: peer and third local bank hold separate data
        load_rf(5);
        xfer(1, 14, 20, 0, 16, "R5");
        load_rf(6);
        xfer(1, 12, 20, 2, 10, "R5");
        dump_bank(14, "R5");
        dump_bank(12, "R5");
        dump_bank(11, "R5");

        // R3: exchange
        load_rf(7);
        xfer(1, 11, 5, 0, 12, "R3");
        load_rf(8);
        xfer(2, 11, 5, 2, 6, "R3");
        check_rf("R3");
        load_rf(9);
        dump_bank(11, "R3");

        // R6: fill pseudo-devices, banks untouched
        load_rf(10);
        xfer(0, 254, 30, 3, 5, "R6");
        check_rf("R6");
        xfer(0, 255, 0, 1, 7, "R6");
        check_rf("R6");

        // R7: refusals, nothing moves
        load_rf(11);
        xfer(0, 13, 0, 0, 4, "R7");
        xfer(1, 254, 0, 0, 4, "R7");
        xfer(2, 255, 0, 0, 4, "R7");
        xfer(3, 10, 0, 0, 4, "R7");
        check_rf("R7");

        // R8: bound
        xfer(1, 12, 31, 1, 4, "R8");
        xfer(0, 12, 31, 0, 4, "R8");
        check_rf("R8");

        // R9: zero length
        xfer(1, 10, 7, 2, 0, "R9");
        check_rf("R9");

        // R10: request while busy is ignored
        load_rf(12);
        start_req(1, 10, 0, 0, 8, "R10");
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_dev = 8'd12;
        req_reg = 5'd0; req_lane = 2'd0; req_len = 8'd8;
        chk(busy == 1'b1, "R10", "busy during transfer", busy, 1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        load_rf(13);
        dump_bank(12, "R10");

        // final image of every bank
        for (int d = 10; d <= 14; d++)
            if (d != 13) dump_bank(d, "R1");

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule